// File: doc/BRIEF.md
# DS0 Transmit Payload Conditioner

This block sits in the transmit path of a T1 framer and handles one 8-bit DS0 octet per time slot, with 24 slots in a frame. Each octet arrives with its slot number (1 to 24), a flag that marks a robbed-bit signaling frame, and the signaling bit for that slot. The block returns the octet one clock later. It can change the octet in one of two ways. It can replace the octet with a stored per-channel idle code. Or it can stop an all-zero octet from reaching the line by stuffing a one into it or by swapping it for a fixed code. Which change applies is set per channel.

A single write port fills two per-channel tables. One table holds a channel control word: a conditioning field and a zero-suppression selector. The other holds the channel's idle code octet. A common use is external T1DM framing. Writing 0xBC as slot 24's idle code and selecting substitution for slot 24 makes slot 24 of every frame carry 0xBC.

Bit naming runs from bit 1 (MSB) to bit 8 (LSB), so bit 7 is value 0x02 and bit 8 is value 0x01.

Top module: `ds0_tx_conditioner`

## Requirements
- R1: While reset is high, and on the first edge after it falls, out_valid is 0. After reset every channel's control word is 0 and every idle code is 0x00, so any octet comes out unchanged.
- R2: An octet presented with in_valid in one cycle appears on out_octet in the next cycle, with out_valid high and out_slot equal to its slot. A cycle without in_valid gives out_valid low in the next cycle.
- R3: A write with wr_sel=0 stores a control word. wr_data[3:0] is the conditioning field and wr_data[5:4] is the suppression selector. wr_data[7:6] are ignored. A write with wr_sel=1 stores wr_data as the channel's idle code.
- R4: Conditioning value 0100 replaces the octet with the channel's idle code. This takes priority over suppression, and the idle code is sent unaltered even when it is 0x00.
- R5: Any conditioning value other than 0100 behaves like 0000. The octet passes to suppression and the idle code is not used.
- R6: With selector 01, an all-zero octet is sent as 0x02 (bit 7 set).
- R7: With selector 10, an all-zero octet in a non-signaling frame is sent as 0x01 (bit 8 set), whatever the signaling bit.
- R8: With selector 10, an all-zero octet in a signaling frame is sent as 0x02 when its signaling bit is 0, and as 0x00 when its signaling bit is 1.
- R9: With selector 11, an all-zero octet is sent as 0x98.
- R10: No suppression mode changes a nonzero octet. Selector 00 leaves an all-zero octet as 0x00.
- R11: A write takes effect from the cycle after the write. An octet of the same slot presented in the same cycle as the write still uses the previous settings.
- R12: Writes to slot numbers outside 1..24 change nothing. Octets carrying such slot numbers pass through unchanged.
- R13: With 0xBC stored as slot 24's idle code and conditioning 0100 on slot 24, slot 24 of every frame carries 0xBC, while the other default-configured slots pass their data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 1 | 0 selects the control word table, 1 selects the idle code table |
| wr_slot | input | 5 | Slot addressed by the write (1..24 valid) |
| wr_data | input | 8 | Write data |
| in_valid | input | 1 | Octet present this cycle |
| in_slot | input | 5 | Slot number of the octet |
| in_sig_frame | input | 1 | Current frame is a robbed-bit signaling frame |
| in_sig_bit | input | 1 | Signaling bit for this slot in this frame |
| in_octet | input | 8 | Payload octet |
| out_valid | output | 1 | Conditioned octet present |
| out_slot | output | 5 | Slot number of the conditioned octet |
| out_octet | output | 8 | Conditioned octet |

## Verification
A configuration write and an octet for the same slot can land in the same cycle. The octet's treatment then depends on whether the lookup sees the old settings or the new ones. The bench forces this case by driving a write that enables 0x98 replacement in the same cycle as an all-zero octet for that slot. It expects 0x00 for that octet, then expects 0x98 for the next octet of the slot. Substitution and suppression can also both be selected for one channel. That case is judged by giving a channel both 0100 and the 0x98 selector with a zero idle code, and expecting 0x00.

// File: rtl/ds0_cond_pkg.sv
package ds0_cond_pkg;

    localparam int SLOTS_DEF = 24;
    localparam int SLOT_W    = 5;
    localparam int OCT_W     = 8;
    localparam int COND_W    = 4;

    typedef enum logic [1:0] {
        ZCS_NONE = 2'b00,
        ZCS_B7   = 2'b01,
        ZCS_GTE  = 2'b10,
        ZCS_DDS  = 2'b11
    } zcs_e;

    // Layout of a stored control word: selector above conditioning field
    typedef struct packed {
        zcs_e              zcs;
        logic [COND_W-1:0] cond;
    } chan_ctl_t;

    localparam int CTL_W = $bits(chan_ctl_t);

    localparam logic [COND_W-1:0] COND_IDLE = 4'b0100;
    localparam logic [OCT_W-1:0]  MARK_B7   = 8'h02;
    localparam logic [OCT_W-1:0]  MARK_B8   = 8'h01;
    localparam logic [OCT_W-1:0]  DDS_CODE  = 8'h98;

    typedef struct packed {
        logic             sig_frame;
        logic             sig_bit;
        logic [OCT_W-1:0] data;
    } octet_in_t;

    function automatic logic slot_ok(input logic [SLOT_W-1:0] s, input int n);
        return (s != '0) && (int'(s) <= n);
    endfunction

    function automatic logic [OCT_W-1:0] zcs_apply(input zcs_e m, input octet_in_t o);
        logic [OCT_W-1:0] r;
        r = o.data;
        if (o.data == '0) begin
            case (m)
                ZCS_B7:  r = MARK_B7;
                ZCS_GTE: r = o.sig_frame ? (o.sig_bit ? o.data : MARK_B7) : MARK_B8;
                ZCS_DDS: r = DDS_CODE;
                default: r = o.data;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ds0_chan_cfg.sv
module ds0_chan_cfg
    import ds0_cond_pkg::*;
#(
    parameter int NUM_SLOTS = SLOTS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [OCT_W-1:0]  wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              rd_hit,
    output chan_ctl_t         rd_ctl,
    output logic [OCT_W-1:0]  rd_idle
);

    chan_ctl_t [NUM_SLOTS-1:0]             ctl_q;
    logic      [NUM_SLOTS-1:0][OCT_W-1:0] idle_q;
    logic      [SLOT_W-1:0]               rd_idx;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic sel_here;
        assign sel_here = wr_en && (wr_slot == SLOT_W'(s + 1));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q[s]  <= '0;
                idle_q[s] <= '0;
            end else if (sel_here) begin
                if (wr_sel) idle_q[s] <= wr_data;
                else        ctl_q[s]  <= chan_ctl_t'(wr_data[CTL_W-1:0]);
            end
        end
    end

    assign rd_hit = slot_ok(rd_slot, NUM_SLOTS);
    assign rd_idx = rd_slot - SLOT_W'(1);

    always_comb begin
        rd_ctl  = '0;
        rd_idle = '0;
        if (rd_hit) begin
            rd_ctl  = ctl_q[rd_idx];
            rd_idle = idle_q[rd_idx];
        end
    end

    // R12: a write aimed outside the slot range leaves both tables untouched
    a_r12_wr_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !slot_ok(wr_slot, NUM_SLOTS)) |=> ($stable(ctl_q) && $stable(idle_q)));

endmodule

// File: rtl/ds0_octet_shaper.sv
module ds0_octet_shaper
    import ds0_cond_pkg::*;
(
    input  logic             hit,
    input  chan_ctl_t        ctl,
    input  logic [OCT_W-1:0] idle_code,
    input  octet_in_t        oct,
    output logic [OCT_W-1:0] shaped
);

    logic use_idle;
    logic [OCT_W-1:0] suppressed;

    assign use_idle   = hit && (ctl.cond == COND_IDLE);
    assign suppressed = zcs_apply(hit ? ctl.zcs : ZCS_NONE, oct);
    assign shaped     = use_idle ? idle_code : suppressed;

    always_comb begin
        // R10: nonzero data outside substitution is never touched
        if (!use_idle && oct.data != '0)
            a_r10_nonzero_kept: assert (shaped == oct.data);
        // R6 R7 R8 R9: an active selector breaks an all-zero octet,
        // except the signaling-frame case with signaling bit 1
        if (!use_idle && hit && ctl.zcs != ZCS_NONE && oct.data == '0 &&
            !(ctl.zcs == ZCS_GTE && oct.sig_frame && oct.sig_bit))
            a_r6_zero_broken: assert (shaped != '0);
    end

endmodule

// File: rtl/ds0_tx_conditioner.sv
module ds0_tx_conditioner
    import ds0_cond_pkg::*;
#(
    parameter int NUM_SLOTS = SLOTS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [OCT_W-1:0]  wr_data,
    input  logic              in_valid,
    input  logic [SLOT_W-1:0] in_slot,
    input  logic              in_sig_frame,
    input  logic              in_sig_bit,
    input  logic [OCT_W-1:0]  in_octet,
    output logic              out_valid,
    output logic [SLOT_W-1:0] out_slot,
    output logic [OCT_W-1:0]  out_octet
);

    logic             hit;
    chan_ctl_t        ctl;
    logic [OCT_W-1:0] idle_code;
    logic [OCT_W-1:0] shaped;
    octet_in_t        oct;

    assign oct = '{sig_frame: in_sig_frame, sig_bit: in_sig_bit, data: in_octet};

    ds0_chan_cfg #(.NUM_SLOTS(NUM_SLOTS)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .rd_slot (in_slot),
        .rd_hit  (hit),
        .rd_ctl  (ctl),
        .rd_idle (idle_code)
    );

    ds0_octet_shaper u_shape (
        .hit       (hit),
        .ctl       (ctl),
        .idle_code (idle_code),
        .oct       (oct),
        .shaped    (shaped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_slot  <= '0;
            out_octet <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_slot  <= in_slot;
                out_octet <= shaped;
            end
        end
    end

    // R2: one cycle of latency, valid and slot carried along
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_slot == $past(in_slot)));
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R12: octets outside the slot range pass unchanged
    a_r12_range_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !slot_ok(in_slot, NUM_SLOTS)) |=> (out_octet == $past(in_octet)));

endmodule

// File: tb/ds0_tx_conditioner_test.sv
`timescale 1ns/1ps
module ds0_tx_conditioner_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [4:0] wr_slot = '0;
    logic [7:0] wr_data = '0;
    logic       in_valid = 1'b0;
    logic [4:0] in_slot = '0;
    logic       in_sig_frame = 1'b0;
    logic       in_sig_bit = 1'b0;
    logic [7:0] in_octet = '0;
    logic       out_valid;
    logic [4:0] out_slot;
    logic [7:0] out_octet;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ds0_tx_conditioner uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_slot(wr_slot), .wr_data(wr_data),
        .in_valid(in_valid), .in_slot(in_slot), .in_sig_frame(in_sig_frame),
        .in_sig_bit(in_sig_bit), .in_octet(in_octet),
        .out_valid(out_valid), .out_slot(out_slot), .out_octet(out_octet)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic write_cfg(input logic sel, input logic [4:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_slot = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_chk(input logic [4:0] s, input logic sf, input logic sb,
                            input logic [7:0] d, input logic [7:0] exp, input string tag);
        in_valid = 1'b1; in_slot = s; in_sig_frame = sf; in_sig_bit = sb; in_octet = d;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, {7'd0, out_valid}, 8'd1);
        check({tag, " slot"}, {3'd0, out_slot}, {3'd0, s});
        check(tag, out_octet, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 out_valid after reset", {7'd0, out_valid}, 8'd0);
        send_chk(5'd1,  1'b0, 1'b0, 8'h00, 8'h00, "R1 slot1 zero");
        send_chk(5'd12, 1'b1, 1'b0, 8'h00, 8'h00, "R1 slot12 zero");
        send_chk(5'd24, 1'b0, 1'b0, 8'h3C, 8'h3C, "R1 slot24 data");
    endtask

    task automatic t_latency();
        send_chk(5'd2, 1'b0, 1'b0, 8'hA5, 8'hA5, "R2 latency");
        @(negedge clk);
        check("R2 valid drops", {7'd0, out_valid}, 8'd0);
    endtask

    task automatic t_bit7();
        write_cfg(1'b0, 5'd3, 8'h10);
        send_chk(5'd3, 1'b0, 1'b0, 8'h00, 8'h02, "R6 zero stuffed");
        send_chk(5'd3, 1'b1, 1'b0, 8'h40, 8'h40, "R10 b7 nonzero");
    endtask

    task automatic t_gte();
        write_cfg(1'b0, 5'd5, 8'h20);
        send_chk(5'd5, 1'b0, 1'b0, 8'h00, 8'h01, "R7 nonsig zero");
        send_chk(5'd5, 1'b0, 1'b1, 8'h00, 8'h01, "R7 nonsig zero sigbit1");
        send_chk(5'd5, 1'b1, 1'b0, 8'h00, 8'h02, "R8 sig frame sigbit0");
        send_chk(5'd5, 1'b1, 1'b1, 8'h00, 8'h00, "R8 sig frame sigbit1");
        send_chk(5'd5, 1'b1, 1'b0, 8'h80, 8'h80, "R10 gte nonzero");
    endtask

    task automatic t_dds();
        write_cfg(1'b0, 5'd7, 8'h30);
        send_chk(5'd7, 1'b0, 1'b0, 8'h00, 8'h98, "R9 zero replaced");
        send_chk(5'd7, 1'b1, 1'b1, 8'h00, 8'h98, "R9 sig frame zero");
        send_chk(5'd7, 1'b0, 1'b0, 8'h01, 8'h01, "R10 dds nonzero");
        send_chk(5'd8, 1'b0, 1'b0, 8'h00, 8'h00, "R10 selector 00 zero");
    endtask

    task automatic t_idle();
        write_cfg(1'b1, 5'd10, 8'h5A);
        write_cfg(1'b0, 5'd10, 8'hF4);  // R3: bits 7:6 ignored, DDS + 0100
        send_chk(5'd10, 1'b0, 1'b0, 8'h00, 8'h5A, "R4 idle over zero");
        send_chk(5'd10, 1'b0, 1'b0, 8'h33, 8'h5A, "R4 idle over data");
        write_cfg(1'b1, 5'd10, 8'h00);
        send_chk(5'd10, 1'b0, 1'b0, 8'h00, 8'h00, "R4 zero idle not suppressed");
        write_cfg(1'b0, 5'd10, 8'hC0);  // R3: upper bits only, yields plain pass
        send_chk(5'd10, 1'b0, 1'b0, 8'h00, 8'h00, "R3 upper bits ignored");
    endtask

    task automatic t_reserved();
        write_cfg(1'b1, 5'd11, 8'h77);
        write_cfg(1'b0, 5'd11, 8'h35);
        send_chk(5'd11, 1'b0, 1'b0, 8'h00, 8'h98, "R5 reserved cond suppresses");
        send_chk(5'd11, 1'b0, 1'b0, 8'h22, 8'h22, "R5 reserved cond passes");
        write_cfg(1'b0, 5'd11, 8'h0C);
        send_chk(5'd11, 1'b0, 1'b0, 8'h00, 8'h00, "R5 cond 1100 no idle");
    endtask

    task automatic t_same_cycle();
        wr_en = 1'b1; wr_sel = 1'b0; wr_slot = 5'd14; wr_data = 8'h30;
        send_chk(5'd14, 1'b0, 1'b0, 8'h00, 8'h00, "R11 old settings in write cycle");
        wr_en = 1'b0;
        send_chk(5'd14, 1'b0, 1'b0, 8'h00, 8'h98, "R11 new settings next octet");
    endtask

    task automatic t_range();
        write_cfg(1'b0, 5'd0,  8'h34);
        write_cfg(1'b1, 5'd0,  8'hAA);
        write_cfg(1'b0, 5'd25, 8'h34);
        write_cfg(1'b1, 5'd25, 8'hAA);
        write_cfg(1'b0, 5'd31, 8'h14);
        send_chk(5'd0,  1'b0, 1'b0, 8'h00, 8'h00, "R12 slot0 passes");
        send_chk(5'd25, 1'b0, 1'b0, 8'h00, 8'h00, "R12 slot25 passes");
        send_chk(5'd31, 1'b1, 1'b0, 8'h6E, 8'h6E, "R12 slot31 passes");
        send_chk(5'd1,  1'b0, 1'b0, 8'h00, 8'h00, "R12 slot1 untouched");
        send_chk(5'd24, 1'b0, 1'b0, 8'h00, 8'h00, "R12 slot24 untouched");
    endtask

    task automatic t_t1dm();
        do_reset();
        write_cfg(1'b1, 5'd24, 8'hBC);
        write_cfg(1'b0, 5'd24, 8'h04);
        for (int f = 0; f < 3; f++) begin
            for (int s = 1; s <= 24; s++) begin
                logic [7:0] d;
                d = 8'(s * 9 + f + 1);
                send_chk(5'(s), (f == 1), 1'b0, d, (s == 24) ? 8'hBC : d,
                         (s == 24) ? "R13 slot24 code" : "R13 other slot");
            end
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_bit7();
        t_gte();
        t_dds();
        t_idle();
        t_reserved();
        t_same_cycle();
        t_range();
        t_t1dm();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule